// File: doc/BRIEF.md
# Two-Phase Opcode Steering Decoder

This block sits between the fetch and execution stages of a pipeline whose stages hand work to each other with two-phase (transition) signalling. The fetch stage presents a 6-bit opcode together with a request wire, and a new request is signalled by toggling that wire. The block answers every request by toggling its acknowledge wire. On the same clock edge it steers the request event onto exactly one of three per-type event wires, chosen by the two low opcode bits. The remaining upper opcode bits go, untouched, to the execution stage.

Each of the three lanes is a select element. It takes a boolean steer, which is high when the opcode names that lane's instruction type. On each request event it toggles its true wire if the steer is high and its false wire if the steer is low. The false wires are brought out but the rest of the pipeline does not use them. The control is a two-state handshake machine. State PH_LOW means the acknowledge wire is low. State PH_HIGH means it is high. The transition PH_LOW→PH_HIGH is taken when the request is seen high. The transition PH_HIGH→PH_LOW is taken when the request is seen low. Every transition is one request event. When the request matches the current phase, the machine holds its state.

Top module: `op_steer_decoder`

## Requirements
- R1: While reset is asserted and after it is released, the acknowledge, all true and false event wires, the forwarded function field and the illegal flag are all 0.
- R2: A request event is present in a clock cycle when the request differs from the acknowledge. At the next rising edge, the acknowledge takes the request's value, so it toggles once per event.
- R3: On an event, opcode bits [1:0] = 11 toggle `evt_true[2]` (J-type), 10 toggle `evt_true[1]` (R-type) and 01 toggle `evt_true[0]` (I-type). The other two true wires do not change.
- R4: On every event, each lane toggles exactly one of its two wires: the true wire if its type was selected, otherwise its false wire (`evt_false[k]` pairs with `evt_true[k]`).
- R5: On an event whose opcode bits [1:0] are 00, no true wire toggles and all three false wires toggle. The event is still acknowledged, and `illegal` becomes 1 and stays 1 until reset.
- R6: On every event, `exec_func` takes opcode bits [5:2] as they are in the cycle of the event, and it holds that value until the next event.
- R7: In a cycle with no event, opcode changes have no effect: the event wires, `exec_func`, `illegal` and the acknowledge are unchanged.
- R8: Events in consecutive cycles, with the request toggled every cycle, are each decoded with their own opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stage_req | input | 1 | Two-phase request from fetch; each toggle is one event |
| opcode | input | 6 | Opcode bundled with the request |
| stage_ack | output | 1 | Two-phase acknowledge; toggles once per event |
| evt_true | output | 3 | Per-type true event wires: [0] I-type, [1] R-type, [2] J-type |
| evt_false | output | 3 | Per-lane false event wires (unused downstream) |
| exec_func | output | 4 | Opcode bits [5:2] captured on the last event |
| illegal | output | 1 | Sticky flag set by an event carrying code 00 |

## Verification
The bench sends events carrying each of the four low-bit codes. This shows whether each code reaches its own lane, and whether code 00 toggles only false wires and sets the flag. It also changes the opcode while the request stays still, to show that level changes without an event are ignored. Bursts of back-to-back toggles with random opcodes check that each event is decoded with its own opcode and not the one from the cycle before. Throughout, a behavioural model tracks the expected phase and wire levels every clock.

// File: rtl/op_steer_pkg.sv
package op_steer_pkg;
    localparam int OPC_W     = 6;
    localparam int STEER_W   = 2;
    localparam int NUM_TYPES = 3;
    localparam int FUNC_W    = OPC_W - STEER_W;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_t;
endpackage

// File: rtl/op_steer_phase.sv
module op_steer_phase
    import op_steer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic ack,
    output logic fire
);
    phase_t state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            PH_LOW:  if (req)  state_nx = PH_HIGH;
            PH_HIGH: if (!req) state_nx = PH_LOW;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= PH_LOW;
        else        state <= state_nx;
    end

    always_comb begin
        ack  = 1'b0;
        fire = 1'b0;
        unique case (state)
            PH_LOW:  begin ack = 1'b0; fire = req;  end
            PH_HIGH: begin ack = 1'b1; fire = !req; end
        endcase
    end

    // R2: the acknowledge follows an event's request level one edge later
    p_ack_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (ack == $past(req)));
endmodule

// File: rtl/op_steer_select.sv
module op_steer_select (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic steer,
    output logic t_out,
    output logic f_out
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_out <= 1'b0;
            f_out <= 1'b0;
        end else if (fire) begin
            if (steer) t_out <= ~t_out;
            else       f_out <= ~f_out;
        end
    end

    // R4: one event moves exactly one of the two wires of a lane
    p_one_side_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> ($stable(t_out) != $stable(f_out)));
    // R7: no event, no movement
    p_lane_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> ($stable(t_out) && $stable(f_out)));
endmodule

// File: rtl/op_steer_decoder.sv
module op_steer_decoder
    import op_steer_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 stage_req,
    input  logic [OPC_W-1:0]     opcode,
    output logic                 stage_ack,
    output logic [NUM_TYPES-1:0] evt_true,
    output logic [NUM_TYPES-1:0] evt_false,
    output logic [FUNC_W-1:0]    exec_func,
    output logic                 illegal
);
    logic                 fire;
    logic [NUM_TYPES-1:0] steer;
    logic                 code_none;

    op_steer_phase u_phase (
        .clk  (clk),
        .rst_n(rst_n),
        .req  (stage_req),
        .ack  (stage_ack),
        .fire (fire)
    );

    for (genvar k = 0; k < NUM_TYPES; k++) begin : g_lane
        assign steer[k] = (opcode[STEER_W-1:0] == STEER_W'(k + 1));
        op_steer_select u_sel (
            .clk  (clk),
            .rst_n(rst_n),
            .fire (fire),
            .steer(steer[k]),
            .t_out(evt_true[k]),
            .f_out(evt_false[k])
        );
    end

    assign code_none = (opcode[STEER_W-1:0] == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exec_func <= '0;
            illegal   <= 1'b0;
        end else if (fire) begin
            exec_func <= opcode[OPC_W-1:STEER_W];
            if (code_none) illegal <= 1'b1;
        end
    end

    // R3: never more than one true wire moves per edge
    p_true_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(evt_true ^ $past(evt_true)) <= 1));
    // R3: a legal code moves exactly one true wire
    p_legal_moves_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !code_none) |=> ($countones(evt_true ^ $past(evt_true)) == 1));
    // R5: code 00 moves no true wire and raises the flag
    p_none_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && code_none) |=> ($stable(evt_true) && illegal));
    // R5: flag is sticky
    p_illegal_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> illegal);
    // R7: without an event the forwarded field holds
    p_func_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> $stable(exec_func));
endmodule

// File: tb/op_steer_decoder_test.sv
module op_steer_decoder_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stage_req = 1'b0;
    logic [5:0] opcode = '0;
    logic       stage_ack;
    logic [2:0] evt_true, evt_false;
    logic [3:0] exec_func;
    logic       illegal;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 0;

    // reference model state
    int m_ack = 0;
    int m_true [3];
    int m_false[3];
    int m_func = 0;
    int m_ill = 0;

    op_steer_decoder uut (
        .clk(clk), .rst_n(rst_n), .stage_req(stage_req), .opcode(opcode),
        .stage_ack(stage_ack), .evt_true(evt_true), .evt_false(evt_false),
        .exec_func(exec_func), .illegal(illegal)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural model, advanced on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ack = 0; m_func = 0; m_ill = 0;
            for (int k = 0; k < 3; k++) begin m_true[k] = 0; m_false[k] = 0; end
        end else if (int'(stage_req) != m_ack) begin
            m_ack = int'(stage_req);
            for (int k = 0; k < 3; k++) begin
                if (int'(opcode[1:0]) == k + 1) m_true[k] = 1 - m_true[k];
                else                            m_false[k] = 1 - m_false[k];
            end
            if (opcode[1:0] == 2'b00) m_ill = 1;
            m_func = int'(opcode[5:2]);
        end
    end

    // compare every cycle, away from the rising edge
    always @(negedge clk) begin
        if (!done) begin
            chk("R2 ack", int'(stage_ack), m_ack);
            for (int k = 0; k < 3; k++) begin
                chk("R3 evt_true", int'(evt_true[k]), m_true[k]);
                chk("R4 evt_false", int'(evt_false[k]), m_false[k]);
            end
            chk("R6 exec_func", int'(exec_func), m_func);
            chk("R5 illegal", int'(illegal), m_ill);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000 && !done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic send(logic [5:0] op);
        @(negedge clk);
        opcode = op;
        stage_req = ~stage_req;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        idle(3);
        // R1: reset state
        chk("R1 ack", int'(stage_ack), 0);
        chk("R1 evt_true", int'(evt_true), 0);
        chk("R1 evt_false", int'(evt_false), 0);
        chk("R1 exec_func", int'(exec_func), 0);
        chk("R1 illegal", int'(illegal), 0);
        @(negedge clk) rst_n = 1'b1;
        idle(2);

        // R3: each legal code with spacing
        send(6'b101011); idle(2);
        chk("R3 J lane", int'(evt_true), 3'b100);
        send(6'b010110); idle(2);
        chk("R3 R lane", int'(evt_true), 3'b110);
        send(6'b111101); idle(2);
        chk("R3 I lane", int'(evt_true), 3'b111);
        chk("R6 func", int'(exec_func), 4'b1111);

        // R7: opcode wiggles without an event
        for (int i = 0; i < 8; i++) begin
            @(negedge clk) opcode = 6'(i * 7 + 1);
        end
        idle(1);
        chk("R7 quiet true", int'(evt_true), 3'b111);
        chk("R7 quiet func", int'(exec_func), 4'b1111);

        // R5: code 00
        send(6'b100100); idle(2);
        chk("R5 no true", int'(evt_true), 3'b111);
        chk("R5 flag", int'(illegal), 1);
        send(6'b000001); idle(2);
        chk("R5 sticky", int'(illegal), 1);

        // R8: back-to-back events with random opcodes
        for (int i = 0; i < 200; i++) send(6'($urandom));
        idle(3);
        for (int i = 0; i < 100; i++) begin
            send(6'($urandom));
            if (i % 3 == 0) begin
                @(negedge clk) opcode = 6'($urandom);
            end
        end
        idle(3);

        // R1: reset clears the flag again
        @(negedge clk) rst_n = 1'b0;
        idle(2);
        chk("R1 flag cleared", int'(illegal), 0);
        chk("R1 ack cleared", int'(stage_ack), 0);
        stage_req = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        send(6'b000010); idle(2);
        chk("R3 R after reset", int'(evt_true), 3'b010);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule